// File: doc/BRIEF.md
# Register file with one-step delayed load writeback

This block is the general register store of a small 32-bit in-order core. It has 32 registers of 32 bits. Register 0 is hard-wired to zero. Every instruction step is marked by a single-cycle strobe. In that cycle the core reads two operands, may write one ALU result, and may hand over a load result for later writeback.

The file keeps two banks. Reads come from the input bank. Each step first commits the pending load pair into the output bank. It then applies the ALU write to the output bank, and at the clock edge that ends the step the whole output bank is copied into the input bank.

A load does not write its target during its own step. It parks an (index, data) pair in a one-entry pending slot. That pair is committed at the start of the next step, so the instruction directly after a load still reads the old value. Results read from coprocessor-0 register 12 (the status register) are returned through the same post port, so they follow the same delay.

Top module: `dl_regfile`

## Requirements
- R1: Both read ports are combinational views of the input bank; reading index 0 always returns 0, even after an ALU write or a load to index 0.
- R2: With step_i high and alu_we_i high, alu_data_i reaches register alu_idx_i in the output bank. The output bank is copied to the input bank at the same edge. Reads in the same cycle return the old value; reads after the edge return the new value.
- R3: A pair posted with post_valid_i during a step is held in the pending slot. The following step still reads the old value. The pair is committed in that following step, so it is readable after that step's edge, two step edges after the post.
- R4: When a step commits the slot and posts nothing new, the slot is cleared to index 0, data 0. A committed pair is therefore written only once, and a later ALU write to that register is not overwritten.
- R5: A pending pair with index 0 changes no register.
- R6: If one step commits a pending pair and writes an ALU result to the same register, the ALU result is kept.
- R7: When step_i is low, alu_we_i and post_valid_i are ignored: no register and no pending pair changes.
- R8: After rst_ni is asserted, all 32 registers read 0 and the pending slot is empty, so the first step commits nothing.
- R9: A post made in the step that commits an earlier post replaces the slot. Both loads land, one step apart, in posting order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One instruction step takes place in this cycle |
| rd_a_idx_i | input | 5 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data (input bank) |
| rd_b_idx_i | input | 5 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data (input bank) |
| alu_we_i | input | 1 | ALU result write enable |
| alu_idx_i | input | 5 | ALU result target register |
| alu_data_i | input | 32 | ALU result value |
| post_valid_i | input | 1 | Post a delayed load or coprocessor-read result |
| post_idx_i | input | 5 | Target register of the delayed result |
| post_data_i | input | 32 | Delayed result value |

## Verification
The hardest case is one step that does three things at once: commit a pair posted one step earlier, write the ALU result to the same register, and accept a new post. Only a post followed directly by a colliding ALU write creates it. The bench builds that sequence on purpose. It then runs an extra empty step and checks that the stale pair has not come back, which it would do if the slot were not cleared. Reads are sampled both before and after each step edge, so the bench sees the one-step window in which a loaded value must still be hidden.

// File: rtl/dl_regfile_pkg.sv
package dl_regfile_pkg;
  parameter int unsigned DEF_NUM_REGS = 32;
  parameter int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_IDX_W   = $clog2(DEF_NUM_REGS);
endpackage

// File: rtl/rf_pend_slot.sv
module rf_pend_slot #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              post_valid_i,
  input  logic [IDX_W-1:0]  post_idx_i,
  input  logic [DATA_W-1:0] post_data_i,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic [DATA_W-1:0] pend_data_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  // slot is consumed by every step; refilled only by a post in that step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (step_i) begin
      idx_q  <= post_valid_i ? post_idx_i  : '0;
      data_q <= post_valid_i ? post_data_i : '0;
    end
  end

  assign pend_idx_o  = idx_q;
  assign pend_data_o = data_q;

  assert_slot_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !post_valid_i) |=> (pend_idx_o == '0 && pend_data_o == '0));

  assert_slot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(pend_idx_o) && $stable(pend_data_o)));
endmodule

// File: rtl/rf_merge.sv
module rf_merge #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] cur_i,
  input  logic [IDX_W-1:0]                commit_idx_i,
  input  logic [DATA_W-1:0]               commit_data_i,
  input  logic                            alu_we_i,
  input  logic [IDX_W-1:0]                alu_idx_i,
  input  logic [DATA_W-1:0]               alu_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] nxt_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign nxt_o[g] = '0;
    end else begin : g_reg
      // commit first, ALU write second: later write wins
      always_comb begin
        nxt_o[g] = cur_i[g];
        if (commit_idx_i == IDX_W'(g)) nxt_o[g] = commit_data_i;
        if (alu_we_i && alu_idx_i == IDX_W'(g)) nxt_o[g] = alu_data_i;
      end
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] d_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [DATA_W-1:0]               data_o
);
  always_comb begin
    data_o = '0;
    if (idx_i != '0 && 32'(idx_i) < NUM_REGS) data_o = bank_i[idx_i];
  end
endmodule

// File: rtl/dl_regfile.sv
module dl_regfile
  import dl_regfile_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              alu_we_i,
  input  logic [IDX_W-1:0]  alu_idx_i,
  input  logic [DATA_W-1:0] alu_data_i,
  input  logic              post_valid_i,
  input  logic [IDX_W-1:0]  post_idx_i,
  input  logic [DATA_W-1:0] post_data_i
);
  logic [NUM_REGS-1:0][DATA_W-1:0] out_q, in_q, merged;
  logic [IDX_W-1:0]                pend_idx;
  logic [DATA_W-1:0]               pend_data;

  rf_pend_slot #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_slot (
    .clk_i, .rst_ni, .step_i, .post_valid_i, .post_idx_i, .post_data_i,
    .pend_idx_o(pend_idx), .pend_data_o(pend_data)
  );

  rf_merge #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_merge (
    .cur_i(out_q), .commit_idx_i(pend_idx), .commit_data_i(pend_data),
    .alu_we_i, .alu_idx_i, .alu_data_i, .nxt_o(merged)
  );

  rf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_out_bank (
    .clk_i, .rst_ni, .load_i(step_i), .d_i(merged), .q_o(out_q)
  );

  // end-of-step copy: input bank takes the updated output bank
  rf_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_in_bank (
    .clk_i, .rst_ni, .load_i(step_i), .d_i(merged), .q_o(in_q)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_a (
    .bank_i(in_q), .idx_i(rd_a_idx_i), .data_o(rd_a_data_o)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rd_b (
    .bank_i(in_q), .idx_i(rd_b_idx_i), .data_o(rd_b_data_o)
  );

  assert_banks_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (in_q == out_q));

  assert_idle_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(in_q) && $stable(out_q)));

  assert_alu_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && alu_we_i && alu_idx_i != '0)
      |=> in_q[$past(alu_idx_i)] == $past(alu_data_i));

  assert_commit_lands_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pend_idx != '0 && !(alu_we_i && alu_idx_i == pend_idx))
      |=> in_q[$past(pend_idx)] == $past(pend_data));
endmodule

// File: tb/sim_dl_regfile.sv
`timescale 1ns/1ps
module sim_dl_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [4:0]  ra = '0, rb = '0;
  logic [31:0] da, db;
  logic        we = 1'b0, pv = 1'b0;
  logic [4:0]  wi = '0, pi = '0;
  logic [31:0] wd = '0, pd = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dl_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step),
    .rd_a_idx_i(ra), .rd_a_data_o(da), .rd_b_idx_i(rb), .rd_b_data_o(db),
    .alu_we_i(we), .alu_idx_i(wi), .alu_data_i(wd),
    .post_valid_i(pv), .post_idx_i(pi), .post_data_i(pd)
  );

  task automatic chk(input logic [4:0] idx, input logic [31:0] exp, input string req);
    ra = idx; rb = idx; #1;
    checks++;
    if (da !== exp || db !== exp) begin
      fails++;
      $display("FAIL %s: r%0d a=%h b=%h expected %h", req, idx, da, db, exp);
    end
  endtask

  // one instruction step; returns at the following falling edge
  task automatic do_step(input bit w, input logic [4:0] widx, input logic [31:0] wdat,
                         input bit p, input logic [4:0] pidx, input logic [31:0] pdat);
    @(negedge clk);
    step = 1'b1; we = w; wi = widx; wd = wdat; pv = p; pi = pidx; pd = pdat;
    @(negedge clk);
    step = 1'b0; we = 1'b0; pv = 1'b0;
  endtask

  task automatic t_reset_r8();
    for (int i = 0; i < 32; i++) chk(5'(i), 32'h0, "R8 reset");
    do_step(0, 0, 0, 0, 0, 0);
    for (int i = 1; i < 32; i += 7) chk(5'(i), 32'h0, "R8 empty slot");
  endtask

  task automatic t_alu_r2();
    @(negedge clk);
    step = 1'b1; we = 1'b1; wi = 5'd2; wd = 32'hA5A5_0001;
    chk(5'd2, 32'h0, "R2 same-cycle read old");
    @(negedge clk);
    step = 1'b0; we = 1'b0;
    chk(5'd2, 32'hA5A5_0001, "R2 after step");
    do_step(1, 5'd0, 32'hFFFF_FFFF, 0, 0, 0);
    chk(5'd0, 32'h0, "R1 r0 after ALU write");
  endtask

  task automatic t_load_delay_r3();
    do_step(1, 5'd7, 32'h1111_0000, 0, 0, 0);
    do_step(0, 0, 0, 1, 5'd7, 32'hDEAD_BEEF);
    chk(5'd7, 32'h1111_0000, "R3 next instr sees old");
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd7, 32'hDEAD_BEEF, "R3 second instr sees load");
  endtask

  task automatic t_collide_r6_r4();
    do_step(0, 0, 0, 1, 5'd9, 32'h0000_0BAD);
    do_step(1, 5'd9, 32'h0000_600D, 1, 5'd12, 32'h0000_0C0C);
    chk(5'd9, 32'h0000_600D, "R6 ALU beats commit");
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd12, 32'h0000_0C0C, "R6 new post still lands");
    chk(5'd9, 32'h0000_600D, "R4 slot cleared no rewrite");
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd9, 32'h0000_600D, "R4 stays after empty step");
  endtask

  task automatic t_zero_load_r5();
    do_step(0, 0, 0, 1, 5'd0, 32'h1234_5678);
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd0, 32'h0, "R5 load to r0");
    chk(5'd7, 32'hDEAD_BEEF, "R5 other reg untouched");
    chk(5'd2, 32'hA5A5_0001, "R5 other reg untouched");
  endtask

  task automatic t_idle_r7();
    @(negedge clk);
    we = 1'b1; wi = 5'd2; wd = 32'h0BAD_0BAD; pv = 1'b1; pi = 5'd3; pd = 32'h0BAD_0003;
    repeat (3) @(negedge clk);
    we = 1'b0; pv = 1'b0;
    chk(5'd2, 32'hA5A5_0001, "R7 ALU write ignored");
    do_step(0, 0, 0, 0, 0, 0);
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd3, 32'h0, "R7 post ignored");
  endtask

  task automatic t_back_to_back_r9();
    do_step(0, 0, 0, 1, 5'd20, 32'hAAAA_0020);
    do_step(0, 0, 0, 1, 5'd21, 32'hBBBB_0021);
    chk(5'd20, 32'hAAAA_0020, "R9 first load landed");
    chk(5'd21, 32'h0, "R9 second load still hidden");
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd21, 32'hBBBB_0021, "R9 second load landed");
    do_step(0, 0, 0, 1, 5'd20, 32'hCCCC_0020);
    do_step(0, 0, 0, 1, 5'd20, 32'hDDDD_0020);
    chk(5'd20, 32'hCCCC_0020, "R9 same target first");
    do_step(0, 0, 0, 0, 0, 0);
    chk(5'd20, 32'hDDDD_0020, "R9 same target last wins");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_r8();
    t_alu_r2();
    t_load_delay_r3();
    t_collide_r6_r4();
    t_zero_load_r5();
    t_idle_r7();
    t_back_to_back_r9();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule